// File: doc/BRIEF.md
# Linked-Descriptor SD Data Mover

This block moves data between system memory and the data FIFO of an SD card interface without processor help for each word. Software builds a chain of descriptors in memory, writes the address of the first one into the block, picks a direction and sets the run bit. The engine fetches each descriptor and transfers the bytes it describes in whole 32-bit words. It then either follows the descriptor's branch address to the next descriptor or stops at a descriptor marked as last.

Every stop leaves a 4-bit result code in the channel register. The code tells apart normal completion, a FIFO that stayed empty or full for too long, a bad or unreadable descriptor, a failed data access, and a chain that ends early. Each stop also raises the interrupt status bit. The interrupt line is that bit gated by an enable. Memory is reached through a word port with a request/acknowledge handshake. The FIFO side is a push port for memory-to-card traffic and a first-word-fall-through pop port for card-to-memory traffic.

Top module: `sd_dma_chain`

## Requirements
- R1: After reset every register reads 0, `irq` is low, and no memory request, push or pop is active.
- R2: Register word 0 (control) keeps bit 0 as the enable and reads it back. Writing it with bit 8 set is a soft reset: every register returns to 0 and a running transfer stops with no further memory requests.
- R3: Register word 4 (channel) holds run in bit 7, direction in bit 22 and the result code in bits 3:0. Writing run=1 while enabled and idle starts a transfer from the address in register word 3 and clears the code, and run reads 1 until the transfer ends. Writing run while disabled has no effect.
- R4: A descriptor is four words at A: flags at A, buffer address at A+4, branch address at A+8, and a reserved word at A+12 that is never read. Flags bits 15:0 are the byte count, rounded up to whole words. Flags bit 31 marks the last descriptor; otherwise the next descriptor is fetched from the branch address.
- R5: With direction 0, words are read from ascending buffer addresses and pushed to the FIFO in that order. A push happens only in a cycle where `fifo_full` is low.
- R6: With direction 1, a word is popped only in a cycle where `fifo_empty` is low, `fifo_rdata` is taken in that same cycle, and the words are written to ascending buffer addresses.
- R7: When the last descriptor's words have all moved, run clears, the code becomes 0xF and the interrupt status (register word 2, bit 0) is set.
- R8: A descriptor with flags bit 30 clear, or an error response on a descriptor read, ends with code 3. An error response on a data access ends with code 4. A byte count of zero ends with code 5.
- R9: If the FIFO stays full for STALL_LIMIT consecutive cycles while a push waits, the transfer ends with code 2. If it stays empty for STALL_LIMIT consecutive cycles while a pop waits, it ends with code 1.
- R10: `irq` is the status bit AND register word 1 bit 0. Writing 1 to status bit 0 clears it, but a transfer end in the same cycle as that write leaves the bit set.
- R11: A memory request keeps its address, write flag and data unchanged until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete this cycle |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| fifo_push | output | 1 | Push `fifo_wdata` into the card FIFO |
| fifo_wdata | output | 32 | Data pushed toward the card |
| fifo_full | input | 1 | FIFO cannot take a word |
| fifo_pop | output | 1 | Take `fifo_rdata` from the card FIFO |
| fifo_rdata | input | 32 | Head word of the card FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| irq | output | 1 | Interrupt request |

## Verification
Software's write-one-to-clear of the status bit and the engine's own end-of-transfer set can land on the same clock edge. The bench provokes this by holding a status-clear write on the register port every cycle of a transfer. It releases the write in the cycle `irq` first appears. The bit must then still read 1 with code 0xF: if the clear won, `irq` would never rise and the bounded wait fails.

// File: rtl/sd_dma_pkg.sv
package sd_dma_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [3:0] {
    RES_NONE  = 4'h0,
    RES_UNDER = 4'h1,
    RES_OVER  = 4'h2,
    RES_DESC  = 4'h3,
    RES_DATA  = 4'h4,
    RES_EARLY = 4'h5,
    RES_OK    = 4'hF
  } res_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_DESC,
    W_MRD,
    W_PUSH,
    W_POP,
    W_MWR
  } wstate_e;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_IEN  = 3'd1;
  localparam logic [2:0] RA_STS  = 3'd2;
  localparam logic [2:0] RA_DPTR = 3'd3;
  localparam logic [2:0] RA_CHAN = 3'd4;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SRST_BIT = 8;
  localparam int CHAN_RUN_BIT  = 7;
  localparam int CHAN_DIR_BIT  = 22;
  localparam int DF_LAST_BIT   = 31;
  localparam int DF_FMT_BIT    = 30;

endpackage

// File: rtl/sd_dma_stall.sv
module sd_dma_stall #(
  parameter int STALL_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wait_i,
  output logic hit
);
  localparam int SCW = $clog2(STALL_LIMIT + 1);

  logic [SCW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr || !wait_i) cnt_d = '0;
    else                cnt_d = cnt_q + SCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = wait_i && (cnt_q == SCW'(STALL_LIMIT - 1));
endmodule

// File: rtl/sd_dma_regs.sv
module sd_dma_regs
  import sd_dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              fin,
  input  res_e              fin_code,
  output logic              srst,
  output logic              start,
  output logic              dir,
  output logic [AW-1:0]     dptr,
  output logic              run,
  output logic [3:0]        code,
  output logic              sts,
  output logic              irq
);
  logic          en_q, en_d;
  logic          ien_q, ien_d;
  logic          sts_q, sts_d;
  logic [AW-1:0] dptr_q, dptr_d;
  logic          dir_q, dir_d;
  logic          run_q, run_d;
  res_e          code_q, code_d;

  logic wr_ctrl, wr_ien, wr_sts, wr_dptr, wr_chan;

  assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
  assign wr_ien  = reg_we && (reg_addr == RA_IEN);
  assign wr_sts  = reg_we && (reg_addr == RA_STS);
  assign wr_dptr = reg_we && (reg_addr == RA_DPTR);
  assign wr_chan = reg_we && (reg_addr == RA_CHAN);

  assign srst  = wr_ctrl && reg_wdata[CTRL_SRST_BIT];
  assign start = wr_chan && reg_wdata[CHAN_RUN_BIT] && en_q && !run_q && !srst;

  always_comb begin
    en_d   = en_q;
    ien_d  = ien_q;
    sts_d  = sts_q;
    dptr_d = dptr_q;
    dir_d  = dir_q;
    run_d  = run_q;
    code_d = code_q;
    if (srst) begin
      en_d   = 1'b0;
      ien_d  = 1'b0;
      sts_d  = 1'b0;
      dptr_d = '0;
      dir_d  = 1'b0;
      run_d  = 1'b0;
      code_d = RES_NONE;
    end else begin
      if (wr_ctrl) en_d = reg_wdata[CTRL_EN_BIT];
      if (wr_ien)  ien_d = reg_wdata[0];
      if (wr_dptr) dptr_d = reg_wdata[AW-1:0];
      if (wr_chan && !run_q) dir_d = reg_wdata[CHAN_DIR_BIT];
      // an end-of-transfer set takes priority over a clear in the same cycle
      if (fin)                       sts_d = 1'b1;
      else if (wr_sts && reg_wdata[0]) sts_d = 1'b0;
      if (start) begin
        run_d  = 1'b1;
        code_d = RES_NONE;
      end else if (fin) begin
        run_d  = 1'b0;
        code_d = fin_code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ien_q  <= 1'b0;
      sts_q  <= 1'b0;
      dptr_q <= '0;
      dir_q  <= 1'b0;
      run_q  <= 1'b0;
      code_q <= RES_NONE;
    end else begin
      en_q   <= en_d;
      ien_q  <= ien_d;
      sts_q  <= sts_d;
      dptr_q <= dptr_d;
      dir_q  <= dir_d;
      run_q  <= run_d;
      code_q <= code_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: reg_rdata[CTRL_EN_BIT] = en_q;
      RA_IEN:  reg_rdata[0] = ien_q;
      RA_STS:  reg_rdata[0] = sts_q;
      RA_DPTR: reg_rdata[AW-1:0] = dptr_q;
      RA_CHAN: begin
        reg_rdata[CHAN_DIR_BIT] = dir_q;
        reg_rdata[CHAN_RUN_BIT] = run_q;
        reg_rdata[3:0]          = code_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata;

  assign dir  = dir_q;
  assign dptr = dptr_q;
  assign run  = run_q;
  assign code = code_q;
  assign sts  = sts_q;
  assign irq  = sts_q && ien_q;
endmodule

// File: rtl/sd_dma_walker.sv
module sd_dma_walker
  import sd_dma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int BCW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              start,
  input  logic              dir,
  input  logic [AW-1:0]     dptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              fifo_push,
  output logic [WORD_W-1:0] fifo_wdata,
  input  logic              fifo_full,
  output logic              fifo_pop,
  input  logic [WORD_W-1:0] fifo_rdata,
  input  logic              fifo_empty,
  output logic              stall_wait,
  input  logic              stall_hit,
  output logic              fin,
  output res_e              fin_code
);
  localparam int WCW = BCW - 1;

  wstate_e           state_q, state_d;
  logic [AW-1:0]     cur_q, cur_d;
  logic [1:0]        widx_q, widx_d;
  logic              last_q, last_d;
  logic              fmt_q, fmt_d;
  logic [BCW-1:0]    count_q, count_d;
  logic [AW-1:0]     buf_q, buf_d;
  logic [AW-1:0]     branch_q, branch_d;
  logic [WCW-1:0]    words_q, words_d;
  logic [WORD_W-1:0] data_q, data_d;

  logic           desc_done;
  logic [BCW:0]   round_up;
  logic           last_word;

  assign round_up  = {1'b0, count_q} + (BCW+1)'(3);
  assign last_word = (words_q == WCW'(1));

  always_comb begin
    state_d    = state_q;
    cur_d      = cur_q;
    widx_d     = widx_q;
    last_d     = last_q;
    fmt_d      = fmt_q;
    count_d    = count_q;
    buf_d      = buf_q;
    branch_d   = branch_q;
    words_d    = words_q;
    data_d     = data_q;
    fin        = 1'b0;
    fin_code   = RES_NONE;
    fifo_push  = 1'b0;
    fifo_pop   = 1'b0;
    stall_wait = 1'b0;
    desc_done  = 1'b0;
    case (state_q)
      W_IDLE: begin
        if (start) begin
          cur_d   = dptr;
          widx_d  = 2'd0;
          state_d = W_DESC;
        end
      end
      W_DESC: begin
        if (mem_ack) begin
          if (mem_err) begin
            fin = 1'b1; fin_code = RES_DESC; state_d = W_IDLE;
          end else begin
            case (widx_q)
              2'd0: begin
                last_d  = mem_rdata[DF_LAST_BIT];
                fmt_d   = mem_rdata[DF_FMT_BIT];
                count_d = mem_rdata[BCW-1:0];
              end
              2'd1:    buf_d = mem_rdata[AW-1:0];
              default: branch_d = mem_rdata[AW-1:0];
            endcase
            if (widx_q == 2'd2) begin
              if (!fmt_q) begin
                fin = 1'b1; fin_code = RES_DESC; state_d = W_IDLE;
              end else if (count_q == '0) begin
                fin = 1'b1; fin_code = RES_EARLY; state_d = W_IDLE;
              end else begin
                words_d = round_up[BCW:2];
                state_d = dir ? W_POP : W_MRD;
              end
            end else begin
              widx_d = widx_q + 2'd1;
            end
          end
        end
      end
      W_MRD: begin
        if (mem_ack) begin
          if (mem_err) begin
            fin = 1'b1; fin_code = RES_DATA; state_d = W_IDLE;
          end else begin
            data_d  = mem_rdata;
            state_d = W_PUSH;
          end
        end
      end
      W_PUSH: begin
        if (!fifo_full) begin
          fifo_push = 1'b1;
          buf_d     = buf_q + AW'(4);
          words_d   = words_q - WCW'(1);
          if (last_word) desc_done = 1'b1;
          else           state_d = W_MRD;
        end else begin
          stall_wait = 1'b1;
          if (stall_hit) begin
            fin = 1'b1; fin_code = RES_OVER; state_d = W_IDLE;
          end
        end
      end
      W_POP: begin
        if (!fifo_empty) begin
          fifo_pop = 1'b1;
          data_d   = fifo_rdata;
          state_d  = W_MWR;
        end else begin
          stall_wait = 1'b1;
          if (stall_hit) begin
            fin = 1'b1; fin_code = RES_UNDER; state_d = W_IDLE;
          end
        end
      end
      W_MWR: begin
        if (mem_ack) begin
          if (mem_err) begin
            fin = 1'b1; fin_code = RES_DATA; state_d = W_IDLE;
          end else begin
            buf_d   = buf_q + AW'(4);
            words_d = words_q - WCW'(1);
            if (last_word) desc_done = 1'b1;
            else           state_d = W_POP;
          end
        end
      end
      default: state_d = W_IDLE;
    endcase
    if (desc_done) begin
      if (last_q) begin
        fin = 1'b1; fin_code = RES_OK; state_d = W_IDLE;
      end else begin
        cur_d   = branch_q;
        widx_d  = 2'd0;
        state_d = W_DESC;
      end
    end
    if (srst) state_d = W_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= W_IDLE;
      cur_q    <= '0;
      widx_q   <= '0;
      last_q   <= 1'b0;
      fmt_q    <= 1'b0;
      count_q  <= '0;
      buf_q    <= '0;
      branch_q <= '0;
      words_q  <= '0;
      data_q   <= '0;
    end else begin
      state_q  <= state_d;
      cur_q    <= cur_d;
      widx_q   <= widx_d;
      last_q   <= last_d;
      fmt_q    <= fmt_d;
      count_q  <= count_d;
      buf_q    <= buf_d;
      branch_q <= branch_d;
      words_q  <= words_d;
      data_q   <= data_d;
    end
  end

  assign mem_req    = (state_q == W_DESC) || (state_q == W_MRD) || (state_q == W_MWR);
  assign mem_we     = (state_q == W_MWR);
  assign mem_addr   = (state_q == W_DESC) ? (cur_q + {{(AW-4){1'b0}}, widx_q, 2'b00}) : buf_q;
  assign mem_wdata  = data_q;
  assign fifo_wdata = data_q;
endmodule

// File: rtl/sd_dma_chain.sv
module sd_dma_chain
  import sd_dma_pkg::*;
#(
  parameter int AW          = 32,
  parameter int BCW         = 16,
  parameter int STALL_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              fifo_push,
  output logic [WORD_W-1:0] fifo_wdata,
  input  logic              fifo_full,
  output logic              fifo_pop,
  input  logic [WORD_W-1:0] fifo_rdata,
  input  logic              fifo_empty,
  output logic              irq
);
  logic [1:0]    rsync_q;
  logic          arst_n;
  logic          srst_w, start_w, dir_w, run_w, sts_w, fin_w;
  logic          stall_wait_w, stall_hit_w;
  logic [AW-1:0] dptr_w;
  logic [3:0]    code_w;
  res_e          fin_code_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  sd_dma_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(arst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fin(fin_w), .fin_code(fin_code_w),
    .srst(srst_w), .start(start_w), .dir(dir_w), .dptr(dptr_w),
    .run(run_w), .code(code_w), .sts(sts_w), .irq(irq)
  );

  sd_dma_walker #(.AW(AW), .BCW(BCW)) u_walker (
    .clk(clk), .rst_n(arst_n), .srst(srst_w), .start(start_w), .dir(dir_w), .dptr(dptr_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_full(fifo_full),
    .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
    .stall_wait(stall_wait_w), .stall_hit(stall_hit_w),
    .fin(fin_w), .fin_code(fin_code_w)
  );

  sd_dma_stall #(.STALL_LIMIT(STALL_LIMIT)) u_stall (
    .clk(clk), .rst_n(arst_n), .clr(srst_w), .wait_i(stall_wait_w), .hit(stall_hit_w)
  );
endmodule

// File: rtl/sd_dma_chain_chk.sv
module sd_dma_chain_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          fifo_push,
  input logic          fifo_full,
  input logic          fifo_pop,
  input logic          fifo_empty,
  input logic          run,
  input logic          sts,
  input logic [3:0]    code,
  input logic          srst,
  input logic          fin,
  input logic [3:0]    fin_code
);
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !srst) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r5_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !fifo_full);

  a_r6_pop_avail: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  a_r3_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(mem_req || fifo_push || fifo_pop));

  a_r7_success: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && fin_code == 4'hF && !srst) |=> (sts && !run && code == 4'hF));

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !srst) |=> sts);

  a_r8_end_has_code: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run) && !$past(srst)) |-> (code != 4'h0));
endmodule

bind sd_dma_chain sd_dma_chain_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(arst_n),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .fifo_push(fifo_push), .fifo_full(fifo_full), .fifo_pop(fifo_pop), .fifo_empty(fifo_empty),
  .run(run_w), .sts(sts_w), .code(code_w), .srst(srst_w),
  .fin(fin_w), .fin_code(fin_code_w)
);

// File: tb/sd_dma_chain_bench.sv
module sd_dma_chain_bench;
  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        fifo_push, fifo_full, fifo_pop, fifo_empty;
  logic [31:0] fifo_wdata, fifo_rdata;
  logic        irq;

  sd_dma_chain u_sd_dma_chain (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_full(fifo_full),
    .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty), .irq(irq)
  );

  localparam logic [2:0] A_CTRL = 3'd0, A_IEN = 3'd1, A_STS = 3'd2, A_DPTR = 3'd3, A_CHAN = 3'd4;

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 0;

  logic [31:0] mem [0:255];
  logic        err_en;
  logic [31:0] err_addr;
  logic [31:0] push_log [0:63];
  int          push_n;
  logic [31:0] pop_src [0:63];
  int          pop_n, pop_idx;
  bit          pop_pend, force_empty;
  bit          seen;
  logic [31:0] seen_addr;
  logic        seen_we;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // memory model: acks one cycle after first seeing a request, error on err_addr
  initial begin
    mem_ack = 0; mem_err = 0; mem_rdata = 0; seen = 0; seen_addr = 0; seen_we = 0;
    forever begin
      @(negedge clk); #1;
      if (mem_ack) begin
        mem_ack = 0; mem_err = 0; seen = 0;
      end else if (mem_req) begin
        if (!seen) begin
          seen = 1; seen_addr = mem_addr; seen_we = mem_we;
        end else begin
          chk(mem_addr == seen_addr && mem_we == seen_we, "R11 request held", mem_addr, seen_addr);
          if (err_en && mem_addr == err_addr) mem_err = 1;
          else if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
          else mem_rdata = mem[mem_addr[9:2]];
          mem_ack = 1; seen = 0;
        end
      end else seen = 0;
    end
  end

  // FIFO push capture
  initial begin
    forever begin
      @(negedge clk); #1;
      if (fifo_push && push_n < 64) begin
        push_log[push_n] = fifo_wdata;
        push_n++;
      end
      if (fifo_pop) pop_pend = 1;
    end
  end

  // FIFO pop source, advances after the edge that consumed the head
  initial begin
    forever begin
      @(posedge clk); #1;
      if (pop_pend) begin pop_idx++; pop_pend = 0; end
      fifo_rdata = pop_src[pop_idx[5:0]];
      fifo_empty = force_empty || (pop_idx >= pop_n);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      rd(A_CHAN, v);
      if (!v[7]) begin ok = 1; break; end
    end
  endtask

  task automatic prep();
    wr(A_CTRL, 32'h100);
    wr(A_CTRL, 32'h1);
    wr(A_IEN, 32'h1);
    err_en = 0; fifo_full = 0; force_empty = 0;
    push_n = 0; pop_n = 0; pop_idx = 0; pop_pend = 0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] fl, input logic [31:0] bf, input logic [31:0] br);
    mem[a >> 2] = fl; mem[(a >> 2) + 1] = bf; mem[(a >> 2) + 2] = br; mem[(a >> 2) + 3] = 32'hBAD0_BAD0;
  endtask

  task automatic go(input logic [31:0] dp, input bit d);
    wr(A_DPTR, dp);
    wr(A_CHAN, ({31'd0, d} << 22) | 32'h80);
  endtask

  task automatic expect_end(input logic [3:0] code, input string req);
    bit ok; logic [31:0] v;
    wait_idle(ok);
    chk(ok, {req, " ends"}, {31'd0, ok}, 32'd1);
    rd(A_CHAN, v);
    chk(v[3:0] == code && !v[7], {req, " code"}, v, {28'd0, code});
    rd(A_STS, v);
    chk(v[0] == 1'b1, {req, " status set"}, v, 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R1 register reset value", v, 0);
    end
    chk(!irq && !mem_req && !fifo_push && !fifo_pop, "R1 outputs idle",
        {28'd0, irq, mem_req, fifo_push, fifo_pop}, 0);
  endtask

  task automatic t_enable_and_gate();
    logic [31:0] v; bit quiet;
    wr(A_CTRL, 32'h100);
    wr(A_CTRL, 32'h1);
    rd(A_CTRL, v);
    chk(v == 32'h1, "R2 enable reads back", v, 1);
    wr(A_CTRL, 32'h0);
    put_desc(32'h40, 32'hC000_0004, 32'h200, 0);
    go(32'h40, 0);
    rd(A_CHAN, v);
    chk(v[7] == 1'b0, "R3 run ignored while disabled", v, 0);
    quiet = 1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); #1; if (mem_req) quiet = 0; end
    chk(quiet, "R3 no request while disabled", {31'd0, quiet}, 1);
  endtask

  task automatic t_tx_chain();
    logic [31:0] v;
    prep();
    for (int i = 0; i < 8; i++) mem[(32'h200 >> 2) + i] = 32'hA000_0000 + i;
    for (int i = 0; i < 8; i++) mem[(32'h300 >> 2) + i] = 32'hB000_0000 + i;
    put_desc(32'h40, 32'h4000_000A, 32'h200, 32'h80);
    put_desc(32'h80, 32'hC000_0008, 32'h300, 32'h0);
    go(32'h40, 0);
    for (int i = 0; i < 24; i++) begin @(negedge clk); fifo_full = (i % 6) < 3; end
    fifo_full = 0;
    expect_end(4'hF, "R7 tx");
    chk(push_n == 5, "R4 tx word count (10B->3, 8B->2)", push_n, 5);
    for (int i = 0; i < 3; i++)
      chk(push_log[i] == 32'hA000_0000 + i, "R5 tx first descriptor order", push_log[i], 32'hA000_0000 + i);
    for (int i = 0; i < 2; i++)
      chk(push_log[3+i] == 32'hB000_0000 + i, "R4 tx branch followed", push_log[3+i], 32'hB000_0000 + i);
    chk(irq == 1'b1, "R10 irq with enable", {31'd0, irq}, 1);
    wr(A_STS, 32'h1);
    rd(A_STS, v);
    chk(v[0] == 0 && !irq, "R10 status write-one-clear", v, 0);
  endtask

  task automatic t_rx_chain();
    logic [31:0] v;
    prep();
    for (int i = 0; i < 4; i++) mem[(32'h3A0 >> 2) + i] = 0;
    for (int i = 0; i < 3; i++) pop_src[i] = 32'hC0DE_0000 + i;
    pop_n = 3; force_empty = 1;
    put_desc(32'hC0, 32'h4000_0004, 32'h3A0, 32'hD0);
    put_desc(32'hD0, 32'hC000_0007, 32'h3B0, 32'h0);
    go(32'hC0, 1);
    repeat (12) @(negedge clk);
    force_empty = 0;
    expect_end(4'hF, "R7 rx");
    chk(mem[32'h3A0 >> 2] == 32'hC0DE_0000, "R6 rx word 0", mem[32'h3A0 >> 2], 32'hC0DE_0000);
    chk(mem[32'h3B0 >> 2] == 32'hC0DE_0001, "R6 rx word 1", mem[32'h3B0 >> 2], 32'hC0DE_0001);
    chk(mem[(32'h3B0 >> 2) + 1] == 32'hC0DE_0002, "R6 rx word 2", mem[(32'h3B0 >> 2) + 1], 32'hC0DE_0002);
    chk(pop_idx == 3, "R6 rx pops", pop_idx, 3);
    rd(A_CHAN, v);
    chk(v[22] == 1'b1, "R3 direction bit reads back", v, 32'h0040_000F);
  endtask

  task automatic t_errors();
    prep();
    put_desc(32'h40, 32'h8000_0004, 32'h200, 0);
    go(32'h40, 0);
    expect_end(4'h3, "R8 format bit clear");
    chk(push_n == 0, "R8 nothing moved on bad format", push_n, 0);

    prep();
    put_desc(32'h40, 32'hC000_0004, 32'h200, 0);
    err_en = 1; err_addr = 32'h48;
    go(32'h40, 0);
    expect_end(4'h3, "R8 descriptor read error");

    prep();
    put_desc(32'h40, 32'hC000_0010, 32'h200, 0);
    err_en = 1; err_addr = 32'h204;
    go(32'h40, 0);
    expect_end(4'h4, "R8 data read error");
    chk(push_n == 1, "R8 one word before data error", push_n, 1);

    prep();
    put_desc(32'h40, 32'h4000_0000, 32'h200, 32'h80);
    go(32'h40, 0);
    expect_end(4'h5, "R8 zero count early end");
  endtask

  task automatic t_stalls();
    prep();
    put_desc(32'h40, 32'hC000_0008, 32'h200, 0);
    fifo_full = 1;
    go(32'h40, 0);
    expect_end(4'h2, "R9 overrun");
    chk(push_n == 0, "R9 no push while full", push_n, 0);

    prep();
    put_desc(32'h40, 32'hC000_0008, 32'h3A0, 0);
    pop_n = 0;
    go(32'h40, 1);
    expect_end(4'h1, "R9 underrun");
  endtask

  task automatic t_soft_reset_mid();
    logic [31:0] v; bit quiet;
    prep();
    wr(A_STS, 32'h1);
    put_desc(32'h40, 32'hC000_0008, 32'h200, 0);
    go(32'h40, 0);
    repeat (2) @(negedge clk);
    wr(A_CTRL, 32'h100);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R2 soft reset clears registers", v, 0);
    end
    quiet = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); #1; if (mem_req || fifo_push) quiet = 0; end
    chk(quiet && push_n == 0, "R2 engine stopped by soft reset", {31'd0, quiet}, 1);
  endtask

  task automatic t_set_vs_clear();
    logic [31:0] v; bit seen_irq;
    prep();
    mem[32'h200 >> 2] = 32'h1234_5678;
    put_desc(32'h40, 32'hC000_0004, 32'h200, 0);
    go(32'h40, 0);
    @(negedge clk); reg_we = 1; reg_addr = A_STS; reg_wdata = 32'h1;
    seen_irq = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      if (irq) begin seen_irq = 1; break; end
    end
    reg_we = 0;
    chk(seen_irq, "R10 set wins over same-cycle clear", {31'd0, seen_irq}, 1);
    rd(A_STS, v);
    chk(v[0] == 1'b1, "R10 status kept", v, 1);
    rd(A_CHAN, v);
    chk(v[3:0] == 4'hF, "R7 code after contested end", v, 32'hF);
  endtask

  initial begin
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    fifo_full = 0; fifo_rdata = 0; fifo_empty = 1; force_empty = 0;
    err_en = 0; err_addr = 0; push_n = 0; pop_n = 0; pop_idx = 0; pop_pend = 0;
    for (int i = 0; i < 256; i++) mem[i] = 0;
    for (int i = 0; i < 64; i++) begin pop_src[i] = 0; push_log[i] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enable_and_gate();
    t_tx_chain();
    t_rx_chain();
    t_errors();
    t_stalls();
    t_soft_reset_mid();
    t_set_vs_clear();
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule